// File: doc/BRIEF.md
# Address Capture RAM Controller

This block controls an external capture memory that records a run of observed bus words, one per pulse of a capture strobe, and lets a host processor read the recording back afterwards. A capture-enable input picks one of two modes. In capture mode a 12-bit counter, built from three 4-bit stages, supplies the memory word address and the strobe paces the writes. In host mode the host address and the host read and write strobes drive the memory directly.

The two edges of each capture strobe do different jobs. The strobe is synchronised into the system clock domain. A falling edge commits the sampled data word to the current counter address with one single-cycle write. The next rising edge then advances the counter. Once location 4095 has been written, a full flag is set and further strobes are ignored until the host clears the counter. The host can read a status word at any time. It holds the counter, the full flag, two sync-state bits and the sync pulse level, so a capture that stopped early can be located.

Top module: `addr_capture_ctrl`

## Requirements
- R1: After reset, and after an accepted clear command, the counter reads 0 and the full flag reads 0 in the status word.
- R2: In capture mode with a valid bank, the first strobe after a clear writes its data word at counter address 0. Each later strobe's rising edge advances the counter by one and its falling edge writes at the new address. After N strobes the status counter reads N-1.
- R3: When the word at counter address 4095 has been written, the full flag reads 1. Further strobes then write nothing and leave the counter at 4095 until a clear.
- R4: In capture mode, memory address bit 12 comes from the two bank select bits. 2'b01 selects bank 0 and 2'b10 selects bank 1. With 2'b00 or 2'b11 a strobe neither writes nor advances the counter.
- R5: In host mode the memory address is the 13-bit host address, and capture strobes are ignored. They write no memory word and leave the counter unchanged.
- R6: A host write with host select high updates bits 15:8 only when byte strobe bit 1 is set, and bits 7:0 only when byte strobe bit 0 is set.
- R7: A host read with host select high returns the stored word on the read data output one clock after the request.
- R8: A status read returns, one clock later, a word laid out as follows: counter in bits 11:0, full flag in bit 12, sync-state bits in bits 14:13, sync pulse level in bit 15.
- R9: A clear command is honoured only while capture-enable is low. While it is high, the command leaves the counter unchanged.
- R10: Each committed capture word produces exactly one single-cycle write pulse on both byte write strobes together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | 1 = capture mode, 0 = host mode |
| cap_strobe | input | 1 | Capture strobe, asynchronous to clk |
| cap_data | input | 16 | Word to capture, held stable across each strobe |
| bank_sel | input | 2 | Bank select for address bit 12 in capture mode |
| host_addr | input | 13 | Host word address |
| host_sel | input | 1 | Host memory select (chip enable) |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 2 | Host byte strobes (bit 1 upper, bit 0 lower) |
| host_wdata | input | 16 | Host write data |
| host_clear | input | 1 | Preload counter to zero and clear full flag |
| host_stat_rd | input | 1 | Status word read request |
| sync_st | input | 2 | Sync state indicator bits |
| sync_pulse | input | 1 | Sync pulse level |
| host_rdata | output | 16 | Read data, memory word or status word |
| cap_full | output | 1 | Full flag |
| mem_addr | output | 13 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ce | output | 1 | Memory chip enable |
| mem_we_hi | output | 1 | Upper byte write strobe |
| mem_we_lo | output | 1 | Lower byte write strobe |
| mem_oe | output | 1 | Memory output enable |
| mem_rdata | input | 16 | Memory read data, valid one clock after mem_oe |

## Verification
Host accesses are driven from a vector table of full-word, single-byte and no-byte writes, each read back. This separates the two byte strobes from each other and shows that host address bit 12 reaches the memory. Short captures into bank 0 and bank 1 are read back to show that words land at consecutive addresses from zero and in the selected half. Invalid bank codes and strobes in host mode must leave earlier words and the counter untouched. A complete 4096-word capture, followed by one more strobe carrying different data, separates a stopping counter from one that wraps or overwrites. Clear commands issued in each mode show the mode gating.

// File: rtl/acap_pkg.sv
package acap_pkg;
    localparam int STAGE_W  = 4;
    localparam int N_STAGES = 3;
    localparam int CNT_W    = STAGE_W * N_STAGES;
    localparam int ADDR_W   = CNT_W + 1;
    localparam int BYTE_W   = 8;
    localparam int DATA_W   = 2 * BYTE_W;
    localparam int SYNC_FF  = 2;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        addr_t addr;
        word_t wdata;
        logic  ce;
        logic  we_hi;
        logic  we_lo;
        logic  oe;
    } mem_req_t;

    typedef struct packed {
        logic ok;
        logic bit12;
    } bank_t;

    function automatic bank_t bank_decode(input logic [1:0] sel);
        bank_t b;
        b.ok    = (sel == 2'b01) || (sel == 2'b10);
        b.bit12 = (sel == 2'b10);
        return b;
    endfunction

    function automatic word_t pack_status(input cnt_t cnt, input logic full,
                                          input logic [1:0] sst, input logic spulse);
        word_t s;
        s = '0;
        s[CNT_W-1:0]       = cnt;
        s[CNT_W]           = full;
        s[CNT_W+2:CNT_W+1] = sst;
        s[CNT_W+3]         = spulse;
        return s;
    endfunction
endpackage

// File: rtl/acap_edge_sync.sv
module acap_edge_sync
    import acap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  word_t data,
    output logic  rise,
    output logic  fall,
    output word_t data_q
);
    logic  sq [SYNC_FF+1];
    word_t dq [SYNC_FF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= SYNC_FF; i++) sq[i] <= 1'b0;
            for (int i = 0; i < SYNC_FF; i++) dq[i] <= '0;
        end else begin
            sq[0] <= strobe;
            dq[0] <= data;
            for (int i = 1; i <= SYNC_FF; i++) sq[i] <= sq[i-1];
            for (int i = 1; i < SYNC_FF; i++) dq[i] <= dq[i-1];
        end
    end

    assign rise   =  sq[SYNC_FF-1] & ~sq[SYNC_FF];
    assign fall   = ~sq[SYNC_FF-1] &  sq[SYNC_FF];
    assign data_q =  dq[SYNC_FF-1];

    a_r10_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rise && fall));
endmodule

// File: rtl/acap_cnt_stage.sv
module acap_cnt_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         load0,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         carry
);
    always_ff @(posedge clk) begin
        if (load0)    q <= '0;
        else if (inc) q <= q + 1'b1;
    end
    assign carry = inc & (&q);
endmodule

// File: rtl/acap_counter.sv
module acap_counter
    import acap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic en,
    input  logic rise,
    input  logic fall,
    output cnt_t cnt,
    output logic full,
    output logic commit
);
    logic [STAGE_W-1:0] stage_q [N_STAGES];
    logic [N_STAGES:0]  carry;
    logic               slot_used;
    logic               advance;
    logic               load0;

    assign load0    = rst | clear;
    assign advance  = en & rise & slot_used & ~full;
    assign commit   = en & fall & ~slot_used & ~full;
    assign carry[0] = advance;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        acap_cnt_stage #(.W(STAGE_W)) u_stage (
            .clk   (clk),
            .load0 (load0),
            .inc   (carry[g]),
            .q     (stage_q[g]),
            .carry (carry[g+1])
        );
    end

    always_comb begin
        for (int i = 0; i < N_STAGES; i++) cnt[i*STAGE_W +: STAGE_W] = stage_q[i];
    end

    always_ff @(posedge clk) begin
        if (load0) begin
            slot_used <= 1'b0;
            full      <= 1'b0;
        end else begin
            if (commit) begin
                slot_used <= 1'b1;
                if (&cnt) full <= 1'b1;
            end else if (advance) begin
                slot_used <= 1'b0;
            end
        end
    end

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0));
    a_r3_full_sticky: assert property (@(posedge clk) disable iff (rst)
        (full && !clear) |=> (full && $stable(cnt)));
    a_r10_one_cycle_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

// File: rtl/acap_mem_ctrl.sv
module acap_mem_ctrl
    import acap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_en,
    input  cnt_t       cnt,
    input  logic       bank_bit,
    input  logic       commit,
    input  word_t      cap_word,
    input  addr_t      host_addr,
    input  logic       host_sel,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [1:0] host_be,
    input  word_t      host_wdata,
    output mem_req_t   req
);
    always_comb begin
        if (cap_en) begin
            req.addr  = {bank_bit, cnt};
            req.wdata = cap_word;
            req.ce    = commit;
            req.we_hi = commit;
            req.we_lo = commit;
            req.oe    = 1'b0;
        end else begin
            req.addr  = host_addr;
            req.wdata = host_wdata;
            req.ce    = host_sel;
            req.we_hi = host_sel & host_wr & host_be[1];
            req.we_lo = host_sel & host_wr & host_be[0];
            req.oe    = host_sel & host_rd;
        end
    end

    a_r10_both_halves: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> (req.we_hi == req.we_lo) && !req.oe);
    a_r5_host_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !host_sel) |-> !req.ce && !req.we_hi && !req.we_lo);
endmodule

// File: rtl/addr_capture_ctrl.sv
module addr_capture_ctrl
    import acap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_en,
    input  logic                cap_strobe,
    input  logic [DATA_W-1:0]   cap_data,
    input  logic [1:0]          bank_sel,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_sel,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [1:0]          host_be,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                host_clear,
    input  logic                host_stat_rd,
    input  logic [1:0]          sync_st,
    input  logic                sync_pulse,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                cap_full,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_ce,
    output logic                mem_we_hi,
    output logic                mem_we_lo,
    output logic                mem_oe,
    input  logic [DATA_W-1:0]   mem_rdata
);
    logic     rise, fall, commit, clear_ok;
    word_t    cap_word, stat_q;
    cnt_t     cnt;
    bank_t    bank;
    mem_req_t req;
    logic     stat_sel_q;

    assign bank     = bank_decode(bank_sel);
    assign clear_ok = host_clear & ~cap_en;

    acap_edge_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .strobe (cap_strobe),
        .data   (cap_data),
        .rise   (rise),
        .fall   (fall),
        .data_q (cap_word)
    );

    acap_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear_ok),
        .en     (cap_en & bank.ok),
        .rise   (rise),
        .fall   (fall),
        .cnt    (cnt),
        .full   (cap_full),
        .commit (commit)
    );

    acap_mem_ctrl u_mem (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (cap_en),
        .cnt        (cnt),
        .bank_bit   (bank.bit12),
        .commit     (commit),
        .cap_word   (cap_word),
        .host_addr  (host_addr),
        .host_sel   (host_sel),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_be    (host_be),
        .host_wdata (host_wdata),
        .req        (req)
    );

    assign mem_addr  = req.addr;
    assign mem_wdata = req.wdata;
    assign mem_ce    = req.ce;
    assign mem_we_hi = req.we_hi;
    assign mem_we_lo = req.we_lo;
    assign mem_oe    = req.oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q     <= '0;
            stat_sel_q <= 1'b0;
        end else begin
            if (host_stat_rd) begin
                stat_q     <= pack_status(cnt, cap_full, sync_st, sync_pulse);
                stat_sel_q <= 1'b1;
            end else if (req.oe) begin
                stat_sel_q <= 1'b0;
            end
        end
    end

    assign host_rdata = stat_sel_q ? stat_q : mem_rdata;

    a_r9_no_drop_in_capture: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (cnt >= $past(cnt)));
    a_r4_bad_bank_no_write: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !$onehot(bank_sel)) |-> !mem_we_hi && !mem_we_lo);
endmodule

// File: tb/addr_capture_ctrl_tb.sv
module addr_capture_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_en = 1'b0, cap_strobe = 1'b0;
    logic [15:0] cap_data = '0;
    logic [1:0]  bank_sel = 2'b01;
    logic [12:0] host_addr = '0;
    logic        host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [1:0]  host_be = 2'b00;
    logic [15:0] host_wdata = '0;
    logic        host_clear = 1'b0, host_stat_rd = 1'b0;
    logic [1:0]  sync_st = 2'b00;
    logic        sync_pulse = 1'b0;
    logic [15:0] host_rdata, mem_wdata;
    logic        cap_full, mem_ce, mem_we_hi, mem_we_lo, mem_oe;
    logic [12:0] mem_addr;
    logic [15:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addr_capture_ctrl u_dut (
        .clk(clk), .rst(rst), .cap_en(cap_en), .cap_strobe(cap_strobe),
        .cap_data(cap_data), .bank_sel(bank_sel), .host_addr(host_addr),
        .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
        .host_be(host_be), .host_wdata(host_wdata), .host_clear(host_clear),
        .host_stat_rd(host_stat_rd), .sync_st(sync_st), .sync_pulse(sync_pulse),
        .host_rdata(host_rdata), .cap_full(cap_full), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ce(mem_ce), .mem_we_hi(mem_we_hi),
        .mem_we_lo(mem_we_lo), .mem_oe(mem_oe), .mem_rdata(mem_rdata)
    );

    bit [15:0] bmem [bit [12:0]];
    always @(posedge clk) begin
        if (mem_ce && mem_we_hi) bmem[mem_addr][15:8] <= mem_wdata[15:8];
        if (mem_ce && mem_we_lo) bmem[mem_addr][7:0]  <= mem_wdata[7:0];
        if (mem_ce && mem_oe) begin
            if (bmem.exists(mem_addr)) mem_rdata <= bmem[mem_addr];
            else                       mem_rdata <= 16'h0000;
        end
    end

    typedef struct packed {
        bit        is_wr;
        bit [12:0] addr;
        bit [1:0]  be;
        bit [15:0] data;
    } hvec_t;

    localparam int NV = 11;
    localparam hvec_t VEC [NV] = '{
        '{1'b1, 13'h0010, 2'b11, 16'h1234},
        '{1'b0, 13'h0010, 2'b00, 16'h1234},
        '{1'b1, 13'h0010, 2'b01, 16'hAAFF},
        '{1'b0, 13'h0010, 2'b00, 16'h12FF},
        '{1'b1, 13'h0010, 2'b10, 16'h56BB},
        '{1'b0, 13'h0010, 2'b00, 16'h56FF},
        '{1'b1, 13'h1FFF, 2'b11, 16'hBEEF},
        '{1'b0, 13'h1FFF, 2'b00, 16'hBEEF},
        '{1'b1, 13'h0FFF, 2'b11, 16'h7777},
        '{1'b1, 13'h0FFF, 2'b00, 16'h0000},
        '{1'b0, 13'h0FFF, 2'b00, 16'h7777}
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic host_write(input logic [12:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_be = be; host_wdata = d; host_sel = 1'b1; host_wr = 1'b1;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [12:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_sel = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic stat_read(output logic [15:0] d);
        @(negedge clk);
        host_stat_rd = 1'b1;
        @(negedge clk);
        host_stat_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic do_clear();
        @(negedge clk);
        host_clear = 1'b1;
        @(negedge clk);
        host_clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [15:0] d);
        @(negedge clk);
        cap_data = d; cap_strobe = 1'b1;
        repeat (3) @(negedge clk);
        cap_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode(input logic en);
        @(negedge clk);
        cap_en = en;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state of status word
        stat_read(v);
        chk("R1 reset status", v, 16'h0000);
        chk("R1 reset full", {15'd0, cap_full}, 16'h0000);

        // R8 status layout
        sync_st = 2'b10; sync_pulse = 1'b1;
        stat_read(v);
        chk("R8 status sync fields", v, 16'hC000);
        sync_st = 2'b01; sync_pulse = 1'b0;
        stat_read(v);
        chk("R8 status sync st bit13", v, 16'h2000);
        sync_st = 2'b00;

        // R6 R7 host vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) host_write(VEC[i].addr, VEC[i].be, VEC[i].data);
            else begin
                host_read(VEC[i].addr, v);
                chk("R6/R7 host vector", v, VEC[i].data);
            end
        end

        // R5 strobes in host mode ignored
        host_write(13'h0000, 2'b11, 16'h5A5A);
        pulse(16'h1111);
        pulse(16'h2222);
        host_read(13'h0000, v);
        chk("R5 host-mode strobe no write", v, 16'h5A5A);
        stat_read(v);
        chk("R5 host-mode strobe no count", v, 16'h0000);

        // R2 capture into bank 0
        bank_sel = 2'b01;
        set_mode(1'b1);
        for (int i = 0; i < 3; i++) pulse(16'hC000 + 16'(i));
        stat_read(v);
        chk("R2 count after 3 strobes", v, 16'h0002);
        // R9 clear ignored in capture mode
        do_clear();
        stat_read(v);
        chk("R9 clear blocked in capture", v, 16'h0002);
        set_mode(1'b0);
        for (int i = 0; i < 3; i++) begin
            host_read(13'(i), v);
            chk("R2 captured word", v, 16'hC000 + 16'(i));
        end
        do_clear();
        stat_read(v);
        chk("R9 clear in host mode", v, 16'h0000);

        // R4 bank 1
        bank_sel = 2'b10;
        set_mode(1'b1);
        for (int i = 0; i < 2; i++) pulse(16'hD000 + 16'(i));
        set_mode(1'b0);
        host_read(13'h1000, v);
        chk("R4 bank1 word0", v, 16'hD000);
        host_read(13'h1001, v);
        chk("R4 bank1 word1", v, 16'hD001);
        host_read(13'h0000, v);
        chk("R4 bank0 untouched", v, 16'hC000);

        // R4 invalid bank codes
        do_clear();
        bank_sel = 2'b11;
        set_mode(1'b1);
        pulse(16'hEEEE);
        bank_sel = 2'b00;
        pulse(16'hEEEE);
        stat_read(v);
        chk("R4 invalid bank no count", v, 16'h0000);
        set_mode(1'b0);
        host_read(13'h0000, v);
        chk("R4 invalid bank no write b0", v, 16'hC000);
        host_read(13'h1000, v);
        chk("R4 invalid bank no write b1", v, 16'hD000);

        // R3 full capture
        do_clear();
        bank_sel = 2'b01;
        set_mode(1'b1);
        for (int i = 0; i < 4096; i++) pulse({4'h9, 12'(i)});
        stat_read(v);
        chk("R3 full status", v, 16'h1FFF);
        chk("R3 full flag", {15'd0, cap_full}, 16'h0001);
        pulse(16'h0BAD);
        stat_read(v);
        chk("R3 status after extra strobe", v, 16'h1FFF);
        set_mode(1'b0);
        host_read(13'h0FFF, v);
        chk("R3 last word kept", v, 16'h9FFF);
        host_read(13'h0000, v);
        chk("R3 first word kept", v, 16'h9000);
        host_read(13'h07FF, v);
        chk("R3 middle word", v, 16'h97FF);
        do_clear();
        stat_read(v);
        chk("R1 clear after full", v, 16'h0000);
        chk("R1 full cleared", {15'd0, cap_full}, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule